// File: doc/BRIEF.md
# Two-Stream Shared-Datapath FIR Lowpass

This block runs one lowpass FIR filter over two independent sample streams. It builds a single set of coefficient multipliers and one adder tree, and it shares them between the two streams. Both streams deliver a sample together at the base rate, marked by a one-cycle strobe. The block runs on a clock at least twice the base rate. In the strobe cycle it filters stream 0. In the following cycle it filters stream 1, using a copy of that stream's sample that it holds from the strobe cycle.

Each stream has its own tap history, and that history advances only in its own slot. The two filtered results come out together on a pair of output registers with a one-cycle valid pulse. The pulse appears two clock edges after the strobe edge, which is one cycle later than a filter per stream would give. Coefficients, tap count, widths and the binary-point position are elaboration parameters.

Top module: `dual_stream_fir`

## Requirements
- R1: A synchronous active-high `rst` clears both tap histories, the stream-1 hold register and both outputs. While `rst` is high and on the edge after it, `out_valid` is 0 and both outputs are 0.
- R2: `y0_out` equals the filtered stream-0 value sum over k of C[k]*x0[n-k], rounded and saturated. C[k] is the signed coefficient held in bits [k*CW +: CW] of `COEFS`, and k=0 multiplies the newest sample.
- R3: `y1_out` is computed in the same way from stream 1's own history only. Samples on one stream never appear in the other stream's result.
- R4: When `strobe` is sampled high on edge E, `out_valid` is high for exactly the cycle between edges E+1 and E+2. At all other times it is low.
- R5: `y0_out` and `y1_out` change only on the edge that raises `out_valid`. Otherwise they hold their values.
- R6: With `ROUND_EN`=1 (the default), the accumulator is shifted right by `FRAC` bits after 2^(FRAC-1) is added. Exact halves therefore round toward plus infinity, so +0.5 LSB gives 1 and -0.5 LSB gives 0.
- R7: A result above 2^(DW-1)-1 is replaced by 2^(DW-1)-1, and a result below -2^(DW-1) is replaced by -2^(DW-1).
- R8: Fast cycles without a strobe and outside the stream-1 slot leave both histories unchanged. Idle gaps between base periods therefore do not alter the results.
- R9: `strobe` is never high on two consecutive edges. This is an input rule, and it is what guarantees the stream-1 slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, at least twice the base rate |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Base-rate pulse marking a new sample pair |
| x0_in | input | DW | Stream 0 sample, signed, valid with `strobe` |
| x1_in | input | DW | Stream 1 sample, signed, valid with `strobe` |
| y0_out | output | DW | Filtered stream 0, signed |
| y1_out | output | DW | Filtered stream 1, signed |
| out_valid | output | 1 | One-cycle pulse marking a new output pair |

## Verification
The bench sends an impulse into stream 0 while stream 1 carries a sinusoid. The impulse brings back the coefficients in tap order, so a reversed or shifted tap ordering shows up at once, and any cross-stream leakage shows up as non-reference values on the idle stream. Exact half-LSB cases in both signs catch truncation or symmetric rounding: those would give 0 instead of 1 for the positive half, or -1 instead of 0 for the negative half. A sign pattern matched to the coefficient signs drives the sum past full scale, which catches wrap-around in place of saturation. Idle gaps between strobes, and a reset in the middle of a run, catch histories that shift on every clock, outputs that drift outside the valid pulse, and state that survives reset.

// File: rtl/dual_stream_fir_pkg.sv
package dual_stream_fir_pkg;

   localparam int NUM_STREAMS = 2;

   typedef enum logic {
      SLOT_S0 = 1'b0,
      SLOT_S1 = 1'b1
   } slot_e;

   // default 8-tap lowpass, Q1.15, tap 0 in the low bits
   localparam logic [8*16-1:0] DEFAULT_COEFS = {
      16'hFE00, 16'h0800, 16'h1400, 16'h2000,
      16'h2400, 16'h1800, 16'h0800, 16'hFC00
   };

endpackage

// File: rtl/dsf_slot_ctrl.sv
module dsf_slot_ctrl
   import dual_stream_fir_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  strobe,
   output logic  slot1_q,
   output slot_e active_slot
);
   // stream 1 owns the cycle after each strobe; a strobe always restarts at stream 0
   always_ff @(posedge clk) begin
      if (rst) slot1_q <= 1'b0;
      else     slot1_q <= strobe;
   end

   assign active_slot = (slot1_q && !strobe) ? SLOT_S1 : SLOT_S0;
endmodule

// File: rtl/dsf_tap_line.sv
module dsf_tap_line #(
   parameter int DW    = 16,
   parameter int DEPTH = 7
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                advance,
   input  logic [DW-1:0]       din,
   output logic [DEPTH*DW-1:0] hist
);
   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst)          hist <= '0;
            else if (advance) hist <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst)          hist <= '0;
            else if (advance) hist <= {hist[(DEPTH-1)*DW-1:0], din};
         end
      end
   endgenerate
endmodule

// File: rtl/dsf_mac.sv
module dsf_mac #(
   parameter int              DW       = 16,
   parameter int              CW       = 16,
   parameter int              TAPS     = 8,
   parameter int              FRAC     = 15,
   parameter bit              ROUND_EN = 1'b1,
   parameter logic [TAPS*CW-1:0] COEFS = '0
) (
   input  logic signed [DW-1:0]        x_new,
   input  logic [(TAPS-1)*DW-1:0]      hist,
   output logic signed [DW-1:0]        y
);
   localparam int PW = DW + CW;
   localparam int AW = PW + $clog2(TAPS);
   localparam logic signed [AW-1:0] HALF = AW'(1) << (FRAC - 1);
   localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [AW-1:0] MINV = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   logic signed [DW-1:0] tap_s [TAPS];
   logic signed [PW-1:0] prod  [TAPS];
   logic signed [AW-1:0] acc, biased, shifted;

   generate
      for (genvar k = 0; k < TAPS; k++) begin : g_tap
         if (k == 0) begin : g_new
            assign tap_s[k] = x_new;
         end else begin : g_old
            assign tap_s[k] = $signed(hist[(k-1)*DW +: DW]);
         end
         assign prod[k] = tap_s[k] * $signed(COEFS[k*CW +: CW]);
      end
   endgenerate

   always_comb begin
      acc = '0;
      for (int k = 0; k < TAPS; k++)
         acc = acc + {{(AW-PW){prod[k][PW-1]}}, prod[k]};
   end

   generate
      if (ROUND_EN) begin : g_round
         assign biased = acc + HALF;
      end else begin : g_trunc
         assign biased = acc;
      end
   endgenerate

   assign shifted = biased >>> FRAC;

   always_comb begin
      if (shifted > MAXV)      y = MAXV[DW-1:0];
      else if (shifted < MINV) y = MINV[DW-1:0];
      else                     y = shifted[DW-1:0];
   end
endmodule

// File: rtl/dual_stream_fir.sv
module dual_stream_fir
   import dual_stream_fir_pkg::*;
#(
   parameter int                 DW       = 16,
   parameter int                 CW       = 16,
   parameter int                 TAPS     = 8,
   parameter int                 FRAC     = 15,
   parameter bit                 ROUND_EN = 1'b1,
   parameter logic [TAPS*CW-1:0] COEFS    = DEFAULT_COEFS
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 strobe,
   input  logic signed [DW-1:0] x0_in,
   input  logic signed [DW-1:0] x1_in,
   output logic signed [DW-1:0] y0_out,
   output logic signed [DW-1:0] y1_out,
   output logic                 out_valid
);
   localparam int HD = TAPS - 1;

   if (TAPS < 2)                 begin : g_bad_taps  $error("TAPS must be at least 2"); end
   if (DW < 2 || CW < 2)         begin : g_bad_width $error("DW and CW must be at least 2"); end
   if (FRAC < 1 || FRAC > DW + CW - 2) begin : g_bad_frac $error("FRAC out of range"); end
   if (NUM_STREAMS != 2)         begin : g_bad_nch   $error("slot control serves two streams"); end

   logic                 slot1_q;
   slot_e                active_slot;
   logic signed [DW-1:0] x1_hold_q;
   logic signed [DW-1:0] y0_part_q;
   logic [HD*DW-1:0]     hist0_q, hist1_q;
   logic signed [DW-1:0] mac_x;
   logic [HD*DW-1:0]     mac_hist;
   logic signed [DW-1:0] mac_y;
   logic                 adv0, adv1;

   dsf_slot_ctrl u_slot (
      .clk        (clk),
      .rst        (rst),
      .strobe     (strobe),
      .slot1_q    (slot1_q),
      .active_slot(active_slot)
   );

   assign adv0 = (active_slot == SLOT_S0) && strobe;
   assign adv1 = (active_slot == SLOT_S1);

   dsf_tap_line #(.DW(DW), .DEPTH(HD)) u_line0 (
      .clk(clk), .rst(rst), .advance(adv0), .din(x0_in), .hist(hist0_q)
   );

   dsf_tap_line #(.DW(DW), .DEPTH(HD)) u_line1 (
      .clk(clk), .rst(rst), .advance(adv1), .din(x1_hold_q), .hist(hist1_q)
   );

   assign mac_x    = (active_slot == SLOT_S1) ? x1_hold_q : x0_in;
   assign mac_hist = (active_slot == SLOT_S1) ? hist1_q   : hist0_q;

   dsf_mac #(
      .DW(DW), .CW(CW), .TAPS(TAPS), .FRAC(FRAC),
      .ROUND_EN(ROUND_EN), .COEFS(COEFS)
   ) u_mac (
      .x_new(mac_x), .hist(mac_hist), .y(mac_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         x1_hold_q <= '0;
         y0_part_q <= '0;
         y0_out    <= '0;
         y1_out    <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= adv1;
         if (adv0) begin
            x1_hold_q <= x1_in;
            y0_part_q <= mac_y;
         end
         if (adv1) begin
            y0_out <= y0_part_q;
            y1_out <= mac_y;
         end
      end
   end
endmodule

// File: rtl/dual_stream_fir_chk.sv
module dual_stream_fir_chk #(
   parameter int DW   = 16,
   parameter int TAPS = 8
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     strobe,
   input logic                     out_valid,
   input logic [DW-1:0]            y0_out,
   input logic [DW-1:0]            y1_out,
   input logic                     slot1_q,
   input logic [(TAPS-1)*DW-1:0]   hist0_q,
   input logic [(TAPS-1)*DW-1:0]   hist1_q
);
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (!out_valid && y0_out == '0 && y1_out == '0));

   p_s1_isolated_r3: assert property (@(posedge clk) disable iff (rst)
      !slot1_q |=> $stable(hist1_q));

   p_valid_follows_r4: assert property (@(posedge clk) disable iff (rst)
      strobe |-> ##2 out_valid);

   p_valid_source_r4: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(strobe, 2));

   p_outputs_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && !$past(rst)) |-> ($stable(y0_out) && $stable(y1_out)));

   p_idle_frozen_r8: assert property (@(posedge clk) disable iff (rst)
      (!strobe && !slot1_q) |=> ($stable(hist0_q) && $stable(hist1_q)));

   p_s0_only_on_strobe_r8: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(hist0_q));

   p_strobe_spacing_r9: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe);
endmodule

bind dual_stream_fir dual_stream_fir_chk #(.DW(DW), .TAPS(TAPS)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .strobe   (strobe),
   .out_valid(out_valid),
   .y0_out   (y0_out),
   .y1_out   (y1_out),
   .slot1_q  (slot1_q),
   .hist0_q  (hist0_q),
   .hist1_q  (hist1_q)
);

// File: tb/dual_stream_fir_tb_top.sv
`timescale 1ns/1ps
module dual_stream_fir_tb_top;
   localparam int DW = 16, CW = 16, TAPS = 8, FRAC = 15;
   localparam int COEF_TBL [TAPS] = '{-1024, 2048, 6144, 9216, 8192, 5120, 2048, -512};
   localparam logic [TAPS*CW-1:0] COEFS_P = {
      16'hFE00, 16'h0800, 16'h1400, 16'h2000,
      16'h2400, 16'h1800, 16'h0800, 16'hFC00};
   localparam int NSTIM = 16;
   localparam int STIM [NSTIM][2] = '{
      '{32767,      0}, '{    0,  12000}, '{    0,  20000}, '{    0,  12000},
      '{    0,      0}, '{    0, -12000}, '{    0, -20000}, '{    0, -12000},
      '{20000,      0}, '{-20000, 12000}, '{20000,  20000}, '{-20000, 12000},
      '{ 9000,      0}, '{-9000, -12000}, '{ 9000, -20000}, '{-9000, -12000}};

   logic clk = 1'b0, rst = 1'b1, strobe = 1'b0;
   logic signed [DW-1:0] x0_in = '0, x1_in = '0;
   logic signed [DW-1:0] y0_out, y1_out;
   logic out_valid;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   int h0 [TAPS], h1 [TAPS];
   int exp0, exp1;

   always #2 clk = ~clk;

   dual_stream_fir #(.DW(DW), .CW(CW), .TAPS(TAPS), .FRAC(FRAC), .ROUND_EN(1'b1),
                     .COEFS(COEFS_P)) dut_i (
      .clk(clk), .rst(rst), .strobe(strobe), .x0_in(x0_in), .x1_in(x1_in),
      .y0_out(y0_out), .y1_out(y1_out), .out_valid(out_valid));

   task automatic chk(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   function automatic int ref_y(input int ch);
      longint acc = 0;
      for (int k = 0; k < TAPS; k++)
         acc += longint'(ch == 0 ? h0[k] : h1[k]) * COEF_TBL[k];
      acc = (acc + (longint'(1) << (FRAC - 1))) >>> FRAC;
      if (acc > 32767)  acc = 32767;
      if (acc < -32768) acc = -32768;
      return int'(acc);
   endfunction

   task automatic model_clear();
      for (int k = 0; k < TAPS; k++) begin h0[k] = 0; h1[k] = 0; end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; strobe = 1'b0;
      @(negedge clk);
      chk("R1 valid in reset", int'(out_valid), 0);
      chk("R1 y0 in reset", int'(y0_out), 0);
      chk("R1 y1 in reset", int'(y1_out), 0);
      rst = 1'b0;
      model_clear();
   endtask

   // one base period: strobe, then result pair, then idle gap cycles
   task automatic period(input int a, input int b, input int gap);
      int s0, s1;
      @(negedge clk);
      strobe = 1'b1; x0_in = DW'(a); x1_in = DW'(b);
      for (int k = TAPS - 1; k > 0; k--) begin h0[k] = h0[k-1]; h1[k] = h1[k-1]; end
      h0[0] = a; h1[0] = b;
      exp0 = ref_y(0); exp1 = ref_y(1);
      @(negedge clk);
      strobe = 1'b0; x0_in = '0; x1_in = '0;
      chk("R4 no valid in stream-0 slot", int'(out_valid), 0);
      @(negedge clk);
      chk("R4 valid after second edge", int'(out_valid), 1);
      chk("R2 y0 matches stream-0 filter", int'(y0_out), exp0);
      chk("R3 y1 matches stream-1 filter", int'(y1_out), exp1);
      s0 = int'(y0_out); s1 = int'(y1_out);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         chk("R4 valid low in gap", int'(out_valid), 0);
         chk("R5 y0 held", int'(y0_out), s0);
         chk("R5 y1 held", int'(y1_out), s1);
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      do_reset();

      // table walk: impulse on stream 0, sinusoid on stream 1
      for (int i = 0; i < NSTIM; i++) begin
         period(STIM[i][0], STIM[i][1], 0);
         if (i < TAPS) chk("R2 impulse returns C[k] in tap order", int'(y0_out), COEF_TBL[i]);
      end

      // R3: stream 1 impulse with stream 0 silent stays out of y0
      do_reset();
      for (int i = 0; i < TAPS; i++) begin
         period(0, (i == 0) ? 32767 : 0, 0);
         chk("R3 no leak into y0", int'(y0_out), 0);
         chk("R3 y1 impulse gives C[k]", int'(y1_out), COEF_TBL[i]);
      end

      // R6: exact half-LSB cases
      do_reset();
      period(0, 8, 0);
      period(0, 0, 0);
      chk("R6 +0.5 LSB rounds to 1", int'(y1_out), 1);
      do_reset();
      period(0, -8, 0);
      period(0, 0, 0);
      chk("R6 -0.5 LSB rounds to 0", int'(y1_out), 0);

      // R7: coefficient-sign-matched full-scale pattern
      do_reset();
      period(-32768, 0, 0);
      for (int i = 0; i < 6; i++) period(32767, 0, 0);
      period(-32768, 0, 0);
      chk("R7 positive saturation", int'(y0_out), 32767);
      period(32767, 0, 0);
      for (int i = 0; i < 6; i++) period(-32768, 0, 0);
      period(32767, 0, 0);
      chk("R7 negative saturation", int'(y0_out), -32768);

      // R8: idle gaps between strobes leave histories alone
      do_reset();
      for (int i = 0; i < 10; i++) period(STIM[i][0] / 2, STIM[i][1], (i % 4) + 1);

      // R1: reset mid-run clears history
      period(20000, -20000, 0);
      do_reset();
      period(32767, 32767, 2);
      chk("R1 history cleared y0", int'(y0_out), COEF_TBL[0]);
      chk("R1 history cleared y1", int'(y1_out), COEF_TBL[0]);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule